// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit operand offset into a 20-bit byte address. It keeps four 16-bit segment base registers (code, stack, extra, data). Each holds the upper 16 bits of the start of a window of up to 64 KB. The byte address is the selected segment value shifted left by four bits plus the offset, and the sum wraps within the 20-bit space. The segments may overlap freely, and two registers may hold the same value.

The offset is built from a base register value, an index register value and a displacement, according to the addressing form. The forms are: direct, base plus displacement, index plus displacement, and base plus index plus displacement. A displacement may be absent, a signed byte, or a full word. The segment comes from the access type:
- Instruction fetches use the code segment.
- Stack accesses use the stack segment.
- Data accesses use the stack segment when the form takes its base from BP, and the data segment otherwise.
- A segment override replaces the default segment, but only for data accesses.

The address path is combinational from the inputs and the registered segment bank. A segment load becomes visible one clock after it is presented.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises until a load, all four segment registers read as zero, so `phys_addr` equals `eff_offset` zero-extended.
- R2: When bit k of `seg_ld_en` is high at a rising clock edge (k: 0 extra, 1 code, 2 stack, 3 data), register k takes `seg_ld_data`. Several bits may load the same value at once. A register whose bit is low keeps its value whatever `seg_ld_data` carries.
- R3: `phys_addr` = (selected segment × 16 + `eff_offset`) mod 2^20.
- R4: `am_mode` selects how the offset is formed:
  - 0 (direct): `eff_offset` = `disp_val`, and `disp_size` is ignored.
  - 1: base + displacement.
  - 2: index + displacement.
  - 3: base + index + displacement.
- R5: In modes 1 to 3, `disp_size` sets the displacement term: 1 gives `disp_val[7:0]` sign-extended to 16 bits, 2 gives `disp_val`, and 0 or 3 gives zero.
- R6: The offset sum wraps modulo 2^16 before the segment is added.
- R7: For a fetch (`access`=1), `seg_used` is 1 (code), and any override is ignored.
- R8: For a stack access (`access`=2), `seg_used` is 2 (stack), and any override is ignored.
- R9: For a data access (`access` 0 or 3) with `ovr_en` low, `seg_used` is 2 (stack) when `am_mode` is 1 or 3 and `base_is_bp` is 1. Otherwise `seg_used` is 3 (data). This includes direct, index-only and BX-based forms.
- R10: For a data access with `ovr_en` high, `seg_used` equals `ovr_sel`, using the same encoding as `seg_used`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_ld_en | input | 4 | Per-register load strobe (0 extra, 1 code, 2 stack, 3 data) |
| seg_ld_data | input | 16 | Value loaded into the strobed registers |
| base_val | input | 16 | Base register value |
| base_is_bp | input | 1 | 1: base is BP, 0: base is BX |
| index_val | input | 16 | Index register value (SI or DI) |
| disp_val | input | 16 | Displacement, or direct offset in mode 0 |
| disp_size | input | 2 | 0 none, 1 signed byte, 2 word, 3 none |
| am_mode | input | 2 | Addressing form |
| access | input | 2 | 0 data, 1 fetch, 2 stack, 3 data |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment |
| phys_addr | output | 20 | Physical byte address |
| eff_offset | output | 16 | Effective offset |
| seg_used | output | 2 | Segment applied |

## Verification
A corrupted segment register has no visible effect until that segment is selected. It then shows as a `phys_addr` off by a multiple of 16 in the same cycle, while `eff_offset` and `seg_used` stay correct. A fault in the segment choice shows at once on `seg_used`, and on `phys_addr` whenever the two registers involved differ. For this reason the bench loads distinct values into each register before it exercises the selection rules. An offset fault shows on both outputs in the same cycle. Faults in carry and wrap only show when the sums cross 2^16 or 2^20, so those crossings are driven on purpose.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_BITS   = 16;
  localparam int OFF_BITS   = 16;
  localparam int PARA_SHIFT = 4;
  localparam int NUM_SEGS   = 4;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_DATA  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_STACK = 2'd2,
    ACC_DATA2 = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    AM_DIRECT     = 2'd0,
    AM_BASE       = 2'd1,
    AM_INDEX      = 2'd2,
    AM_BASE_INDEX = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    DSP_NONE = 2'd0,
    DSP_BYTE = 2'd1,
    DSP_WORD = 2'd2,
    DSP_RSVD = 2'd3
  } dsize_e;

  function automatic logic form_uses_base(amode_e m);
    return (m == AM_BASE) || (m == AM_BASE_INDEX);
  endfunction

  function automatic logic form_uses_index(amode_e m);
    return (m == AM_INDEX) || (m == AM_BASE_INDEX);
  endfunction
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = SEG_BITS,
  parameter int NSEG  = NUM_SEGS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSEG-1:0]           ld_en,
  input  logic [SEG_W-1:0]          ld_data,
  output logic [NSEG-1:0][SEG_W-1:0] bank_q
);
  for (genvar k = 0; k < NSEG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bank_q[k] <= '0;
      else if (ld_en[k]) bank_q[k] <= ld_data;
    end
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import seg_addr_pkg::*;
#(
  parameter int OFF_W = OFF_BITS
) (
  input  amode_e           mode,
  input  dsize_e           dsize,
  input  logic [OFF_W-1:0] base,
  input  logic [OFF_W-1:0] index,
  input  logic [OFF_W-1:0] disp,
  output logic [OFF_W-1:0] eff
);
  localparam int BYTE_W = 8;

  function automatic logic [OFF_W-1:0] disp_term(logic [OFF_W-1:0] d, dsize_e s);
    case (s)
      DSP_BYTE: return {{(OFF_W-BYTE_W){d[BYTE_W-1]}}, d[BYTE_W-1:0]};
      DSP_WORD: return d;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] offset_sum(
    amode_e m, dsize_e s, logic [OFF_W-1:0] b, logic [OFF_W-1:0] x, logic [OFF_W-1:0] d);
    logic [OFF_W-1:0] bt, xt;
    if (m == AM_DIRECT) return d;
    bt = form_uses_base(m)  ? b : '0;
    xt = form_uses_index(m) ? x : '0;
    return bt + xt + disp_term(d, s);
  endfunction

  assign eff = offset_sum(mode, dsize, base, index, disp);
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_addr_pkg::*;
(
  input  acc_e    access,
  input  amode_e  mode,
  input  logic    base_is_bp,
  input  logic    ovr_en,
  input  seg_id_e ovr_sel,
  output seg_id_e dflt_seg,
  output seg_id_e seg_sel
);
  function automatic seg_id_e default_seg(acc_e a, amode_e m, logic bp);
    case (a)
      ACC_FETCH: return SEG_CODE;
      ACC_STACK: return SEG_STACK;
      default:   return (form_uses_base(m) && bp) ? SEG_STACK : SEG_DATA;
    endcase
  endfunction

  logic is_data;
  assign is_data  = (access == ACC_DATA) || (access == ACC_DATA2);
  assign dflt_seg = default_seg(access, mode, base_is_bp);
  assign seg_sel  = (is_data && ovr_en) ? ovr_sel : dflt_seg;
endmodule

// File: rtl/phys_form.sv
module phys_form
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = SEG_BITS,
  parameter int OFF_W = OFF_BITS,
  parameter int SHIFT = PARA_SHIFT
) (
  input  logic [SEG_W-1:0]       seg_val,
  input  logic [OFF_W-1:0]       off,
  output logic [SEG_W+SHIFT-1:0] phys
);
  localparam int PW = SEG_W + SHIFT;

  function automatic logic [PW-1:0] combine(logic [SEG_W-1:0] s, logic [OFF_W-1:0] o);
    logic [PW-1:0] sb, ob;
    sb = {s, {SHIFT{1'b0}}};
    ob = PW'(o);
    return sb + ob;
  endfunction

  assign phys = combine(seg_val, off);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = SEG_BITS,
  parameter int OFF_W = OFF_BITS,
  parameter int SHIFT = PARA_SHIFT,
  parameter int NSEG  = NUM_SEGS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSEG-1:0]        seg_ld_en,
  input  logic [SEG_W-1:0]       seg_ld_data,
  input  logic [OFF_W-1:0]       base_val,
  input  logic                   base_is_bp,
  input  logic [OFF_W-1:0]       index_val,
  input  logic [OFF_W-1:0]       disp_val,
  input  logic [1:0]             disp_size,
  input  logic [1:0]             am_mode,
  input  logic [1:0]             access,
  input  logic                   ovr_en,
  input  logic [1:0]             ovr_sel,
  output logic [SEG_W+SHIFT-1:0] phys_addr,
  output logic [OFF_W-1:0]       eff_offset,
  output logic [1:0]             seg_used
);
  logic [NSEG-1:0][SEG_W-1:0] seg_regs;
  logic [OFF_W-1:0]           off_w;
  seg_id_e                    dflt_w, sel_w;
  logic [SEG_W-1:0]           seg_val_w;

  seg_bank #(.SEG_W(SEG_W), .NSEG(NSEG)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (seg_ld_en),
    .ld_data(seg_ld_data),
    .bank_q (seg_regs)
  );

  ea_calc #(.OFF_W(OFF_W)) u_ea (
    .mode (amode_e'(am_mode)),
    .dsize(dsize_e'(disp_size)),
    .base (base_val),
    .index(index_val),
    .disp (disp_val),
    .eff  (off_w)
  );

  seg_pick u_pick (
    .access    (acc_e'(access)),
    .mode      (amode_e'(am_mode)),
    .base_is_bp(base_is_bp),
    .ovr_en    (ovr_en),
    .ovr_sel   (seg_id_e'(ovr_sel)),
    .dflt_seg  (dflt_w),
    .seg_sel   (sel_w)
  );

  assign seg_val_w = seg_regs[sel_w];

  phys_form #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_phys (
    .seg_val(seg_val_w),
    .off    (off_w),
    .phys   (phys_addr)
  );

  assign eff_offset = off_w;
  assign seg_used   = sel_w;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NSEG-1:0]            seg_ld_en,
  input logic [SEG_W-1:0]           seg_ld_data,
  input logic [NSEG-1:0][SEG_W-1:0] bank,
  input logic [1:0]                 access,
  input logic [1:0]                 am_mode,
  input logic                       base_is_bp,
  input logic                       ovr_en,
  input logic [1:0]                 ovr_sel,
  input logic [1:0]                 seg_used,
  input logic [SEG_W+SHIFT-1:0]     phys_addr,
  input logic [OFF_W-1:0]           eff_offset
);
  localparam int PW = SEG_W + SHIFT;

  for (genvar k = 0; k < NSEG; k++) begin : g_ld
    // R2
    seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_ld_en[k] |=> bank[k] == $past(seg_ld_data));
    // R2
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_ld_en[k] |=> $stable(bank[k]));
  end

  // R3
  phys_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr == PW'({bank[seg_used], {SHIFT{1'b0}}} + PW'(eff_offset)));
  // R7
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access == 2'd1 |-> seg_used == 2'd1);
  // R8
  stack_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access == 2'd2 |-> seg_used == 2'd2);
  // R9
  bp_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access[0] == access[1]) && !ovr_en && am_mode[0] && base_is_bp |-> seg_used == 2'd2);
  // R10
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access[0] == access[1]) && ovr_en |-> seg_used == ovr_sel);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .NSEG(NSEG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seg_ld_en  (seg_ld_en),
  .seg_ld_data(seg_ld_data),
  .bank       (seg_regs),
  .access     (access),
  .am_mode    (am_mode),
  .base_is_bp (base_is_bp),
  .ovr_en     (ovr_en),
  .ovr_sel    (ovr_sel),
  .seg_used   (seg_used),
  .phys_addr  (phys_addr),
  .eff_offset (eff_offset)
);

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  seg_ld_en = 0;
  logic [15:0] seg_ld_data = 0;
  logic [15:0] base_val = 0, index_val = 0, disp_val = 0;
  logic        base_is_bp = 0;
  logic [1:0]  disp_size = 0, am_mode = 0, access = 0, ovr_sel = 0;
  logic        ovr_en = 0;
  logic [19:0] phys_addr;
  logic [15:0] eff_offset;
  logic [1:0]  seg_used;

  int checks = 0, fails = 0;
  bit finished = 0;
  int mseg[4];
  string phase_tag = "";

  always #2 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .seg_ld_en(seg_ld_en), .seg_ld_data(seg_ld_data),
    .base_val(base_val), .base_is_bp(base_is_bp), .index_val(index_val),
    .disp_val(disp_val), .disp_size(disp_size), .am_mode(am_mode), .access(access),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .phys_addr(phys_addr),
    .eff_offset(eff_offset), .seg_used(seg_used)
  );

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_seg();
    if (access == 2'd1) return 1;
    if (access == 2'd2) return 2;
    if (ovr_en) return ovr_sel;
    if ((am_mode == 2'd1 || am_mode == 2'd3) && base_is_bp) return 2;
    return 3;
  endfunction

  // Compares all outputs against the behavioural model, then records loads.
  task automatic step();
    int d, s, off, sg, phys;
    string toff, tseg;
    #1;
    if (disp_size == 2'd1) begin
      d = disp_val[7:0];
      if (d >= 128) d -= 256;
    end else if (disp_size == 2'd2) d = disp_val;
    else d = 0;
    case (am_mode)
      2'd0: s = disp_val;
      2'd1: s = base_val + d;
      2'd2: s = index_val + d;
      default: s = base_val + index_val + d;
    endcase
    off = ((s % 65536) + 65536) % 65536;
    if (s < 0 || s > 65535) toff = "R6";
    else if (am_mode != 0 && disp_size == 2'd1) toff = "R5";
    else toff = "R4";
    sg = model_seg();
    if (access == 2'd1) tseg = "R7";
    else if (access == 2'd2) tseg = "R8";
    else if (ovr_en) tseg = "R10";
    else tseg = "R9";
    phys = (mseg[sg] * 16 + off) % 1048576;
    check_val(toff, eff_offset, off);
    check_val(tseg, seg_used, sg);
    check_val(phase_tag != "" ? phase_tag : "R3", phys_addr, phys);
    if (rst_n) for (int k = 0; k < 4; k++) if (seg_ld_en[k]) mseg[k] = seg_ld_data;
    @(negedge clk);
  endtask

  task automatic set_op(int acc, int mode, int bp, int b, int x, int dsp, int dsz,
                        int oen, int osel);
    access = acc; am_mode = mode; base_is_bp = bp; base_val = b; index_val = x;
    disp_val = dsp; disp_size = dsz; ovr_en = oen; ovr_sel = osel;
  endtask

  task automatic load(int en, int val);
    seg_ld_en = en; seg_ld_data = val;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) mseg[k] = 0;
    @(negedge clk);
    // R1: reset state, segments read zero
    phase_tag = "R1";
    set_op(0, 0, 0, 0, 0, 16'h1234, 0, 0, 0);
    step();
    check_val("R1", phys_addr, 20'h01234);
    set_op(1, 1, 1, 16'hBEEF, 0, 16'h0010, 2, 0, 0);
    step();
    rst_n = 1;
    step();
    // R2: one strobe loads several registers
    phase_tag = "R2";
    load(4'b1111, 16'hA000);
    set_op(0, 0, 0, 0, 0, 16'h0001, 0, 0, 0);
    step();
    load(4'b0000, 16'h5555);
    step();
    check_val("R2", phys_addr, 20'hA0001);
    load(4'b0010, 16'hFFFF); step();
    load(4'b0100, 16'h1000); step();
    load(4'b0001, 16'h2340); step();
    load(4'b1000, 16'h0ABC); step();
    // R2: no strobe, data bus changes, values kept
    load(4'b0000, 16'h7777);
    for (int a = 0; a < 4; a++) begin
      set_op(0, 0, 0, 0, 0, 16'h0002, 0, 1, a);
      step();
    end
    phase_tag = "";
    // R3: 20-bit wrap on fetch from code segment FFFF
    set_op(1, 0, 0, 0, 0, 16'h0010, 0, 0, 0);
    step();
    check_val("R3", phys_addr, 20'h00000);
    // R7: override ignored on fetch
    set_op(1, 3, 1, 16'h0100, 16'h0020, 16'h0003, 2, 1, 0);
    step();
    // R8: override ignored on stack access
    set_op(2, 2, 0, 0, 16'h0040, 16'h0000, 0, 1, 3);
    step();
    // R9: BP base goes to stack, BX/index/direct to data
    set_op(0, 1, 1, 16'h0200, 0, 16'h0004, 2, 0, 0); step();
    set_op(3, 3, 1, 16'h0200, 16'h0010, 16'h0004, 1, 0, 0); step();
    set_op(0, 1, 0, 16'h0200, 0, 16'h0004, 2, 0, 0); step();
    set_op(0, 2, 1, 16'h0200, 16'h0300, 16'h0004, 2, 0, 0); step();
    set_op(0, 0, 1, 16'h0200, 0, 16'h0004, 0, 0, 0); step();
    // R10: override on data access
    set_op(0, 1, 1, 16'h0200, 0, 0, 0, 1, 0); step();
    set_op(3, 2, 0, 0, 16'h0008, 0, 0, 1, 1); step();
    // R5: byte displacement sign-extended, reserved size ignored
    set_op(0, 1, 0, 16'h0000, 0, 16'h1280, 1, 0, 3);
    step();
    check_val("R5", eff_offset, 16'hFF80);
    set_op(0, 2, 0, 0, 16'h0050, 16'h7FFF, 3, 0, 0);
    step();
    check_val("R5", eff_offset, 16'h0050);
    // R6: 16-bit wrap of the offset
    set_op(0, 3, 0, 16'hFFFF, 16'h0002, 0, 0, 0, 0);
    step();
    check_val("R6", eff_offset, 16'h0001);
    // R4: direct form ignores displacement size
    set_op(0, 0, 1, 16'h1111, 16'h2222, 16'h00F0, 1, 0, 0);
    step();
    check_val("R4", eff_offset, 16'h00F0);
    // Random stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      load(($urandom % 4 == 0) ? ($urandom & 15) : 0, $urandom & 16'hFFFF);
      set_op($urandom % 4, $urandom % 4, $urandom % 2, $urandom & 16'hFFFF,
             $urandom & 16'hFFFF, $urandom & 16'hFFFF, $urandom % 4,
             $urandom % 2, $urandom % 4);
      step();
    end
    finish_run();
  end
endmodule